// File: doc/BRIEF.md
# Privileged Side-Effect Register Unit

This unit holds the few privileged control registers of a 64-bit core whose accesses are not plain storage. A read of the page-directory selector returns one of two stored base registers. The choice comes from the top bit of a faulting address, and that address is picked by the refill-in-progress flag. The status register accepts writes only in its two software-interrupt bits. The address-space identifier register accepts writes only in its identifier field, and it raises a one-cycle TLB-flush request whenever the identifier really changes. A timer-clear register drops the pending timer interrupt. A core-identity register returns a fixed index.

Each access is an exchange. In the cycle of the access, `csrRdata` shows the value the addressed register held before that access. A write takes effect at the next rising clock edge. The timer counter drives `timerExpire`, and this unit keeps the pending timer interrupt.

Top module: `csr_side_unit`

## Requirements
- R1: A read of the page-directory selector (address 0x05) works from `refillBadAddr` when `refillEra[0]` is 1, and from `badAddr` when it is 0.
- R2: If bit 63 of the chosen address is 1, the selector read returns the high base register (address 0x04). Otherwise it returns the low base register (address 0x03). Both base registers are fully writable.
- R3: A write to the status register (address 0x01) changes only bits [1:0]. Bit 11 reads the pending timer interrupt, the other bits read zero, and no write alters either.
- R4: While `csrEn` is high, `csrRdata` shows the addressed register's value from before the access, in the same cycle, whether or not the access writes. While `csrEn` is low it reads zero.
- R5: A write to the identifier register (address 0x02) updates only bits [9:0]. Bits [23:16] always read the field width, 10.
- R6: `flushReq` is high for exactly the one cycle after an identifier write that changes bits [9:0]. A write of the unchanged value gives no pulse.
- R7: A write to the timer-clear register (address 0x07) with bit 0 set clears `timerIrq` at the next edge. With bit 0 clear, the write has no effect.
- R8: A read or exchange of the timer-clear register returns zero.
- R9: A read of the core-identity register (address 0x06) returns the parameter `CORE_INDEX`.
- R10: A `timerExpire` pulse sets `timerIrq` at the next edge. If a clear arrives in the same cycle, the set wins.
- R11: Any address not listed above reads zero and ignores writes. Writes to the selector and to the core-identity register are also ignored.
- R12: After reset, `timerIrq` and `flushReq` are 0, and every stored field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrEn | input | 1 | Access valid this cycle |
| csrWe | input | 1 | Access writes |
| csrAddr | input | 8 | Register address |
| csrWdata | input | 64 | Write data |
| csrRdata | output | 64 | Value before the access |
| badAddr | input | 64 | Ordinary faulting address |
| refillBadAddr | input | 64 | Faulting address during TLB refill |
| refillEra | input | 64 | Refill return-address register, bit 0 flags refill |
| timerExpire | input | 1 | One-cycle timer expiry pulse |
| timerIrq | output | 1 | Pending timer interrupt |
| flushReq | output | 1 | One-cycle TLB flush request |

## Verification
The bench drives all four combinations of the refill flag and the top address bit. A swapped selector would return the wrong base register. It writes all ones to the status and identifier registers, where a missing mask would show upper bits or overwrite the width field. It rewrites an unchanged identifier, so a design that compares against the write data alone would flush spuriously. It lands an expiry and a clear in the same cycle, where the wrong priority would leave the interrupt low. Each write is paired with its returned value, which exposes a design that shows the new value instead of the old one.

// File: rtl/csr_side_pkg.sv
package csr_side_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_STATUS = 8'h01;
  localparam logic [ADDR_W-1:0] A_ASID   = 8'h02;
  localparam logic [ADDR_W-1:0] A_PGDLO  = 8'h03;
  localparam logic [ADDR_W-1:0] A_PGDHI  = 8'h04;
  localparam logic [ADDR_W-1:0] A_PGDSEL = 8'h05;
  localparam logic [ADDR_W-1:0] A_COREID = 8'h06;
  localparam logic [ADDR_W-1:0] A_TCLR   = 8'h07;

  localparam int SWI_W        = 2;
  localparam int TIMER_BIT    = 11;
  localparam int WIDTH_FIELD  = 16;

  typedef enum logic [2:0] {
    RD_NONE, RD_STATUS, RD_ASID, RD_PGDLO, RD_PGDHI, RD_PGDSEL, RD_COREID
  } rdSel_e;

  typedef struct packed {
    logic   wrStatus;
    logic   wrAsid;
    logic   wrPgdLo;
    logic   wrPgdHi;
    logic   clrTimer;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/csr_side_ctrl.sv
module csr_side_ctrl
  import csr_side_pkg::*;
(
  input  logic              csrEn,
  input  logic              csrWe,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              wdataBit0,
  output strobe_t           stb
);
  logic wr;
  assign wr = csrEn && csrWe;

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (csrEn) begin
      unique case (csrAddr)
        A_STATUS: stb.rdSel = RD_STATUS;
        A_ASID:   stb.rdSel = RD_ASID;
        A_PGDLO:  stb.rdSel = RD_PGDLO;
        A_PGDHI:  stb.rdSel = RD_PGDHI;
        A_PGDSEL: stb.rdSel = RD_PGDSEL;
        A_COREID: stb.rdSel = RD_COREID;
        default:  stb.rdSel = RD_NONE;
      endcase
    end
    stb.wrStatus = wr && (csrAddr == A_STATUS);
    stb.wrAsid   = wr && (csrAddr == A_ASID);
    stb.wrPgdLo  = wr && (csrAddr == A_PGDLO);
    stb.wrPgdHi  = wr && (csrAddr == A_PGDHI);
    stb.clrTimer = wr && (csrAddr == A_TCLR) && wdataBit0;
  end
endmodule

// File: rtl/csr_side_dp.sv
module csr_side_dp
  import csr_side_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int ASID_W     = 10,
  parameter int CORE_INDEX = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [XLEN-1:0] wdata,
  input  logic [XLEN-1:0] badAddr,
  input  logic [XLEN-1:0] refillBadAddr,
  input  logic            refillFlag,
  input  logic            timerExpire,
  output logic [XLEN-1:0] rdata,
  output logic            flushReq,
  output logic            timerIrq
);
  localparam int TOP = XLEN - 1;

  logic [SWI_W-1:0]  swiBits;
  logic [ASID_W-1:0] asidVal;
  logic [XLEN-1:0]   pgdLo, pgdHi;
  logic [XLEN-1:0]   faultAddr, statusView, asidView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swiBits  <= '0;
      asidVal  <= '0;
      pgdLo    <= '0;
      pgdHi    <= '0;
      flushReq <= 1'b0;
      timerIrq <= 1'b0;
    end else begin
      if (stb.wrStatus) swiBits <= wdata[SWI_W-1:0];
      if (stb.wrAsid)   asidVal <= wdata[ASID_W-1:0];
      if (stb.wrPgdLo)  pgdLo   <= wdata;
      if (stb.wrPgdHi)  pgdHi   <= wdata;
      flushReq <= stb.wrAsid && (wdata[ASID_W-1:0] != asidVal);
      timerIrq <= timerExpire || (timerIrq && !stb.clrTimer);
    end
  end

  always_comb begin
    faultAddr  = refillFlag ? refillBadAddr : badAddr;
    statusView = '0;
    statusView[SWI_W-1:0] = swiBits;
    statusView[TIMER_BIT] = timerIrq;
    asidView   = '0;
    asidView[ASID_W-1:0] = asidVal;
    asidView[WIDTH_FIELD +: 8] = 8'(ASID_W);
    unique case (stb.rdSel)
      RD_STATUS: rdata = statusView;
      RD_ASID:   rdata = asidView;
      RD_PGDLO:  rdata = pgdLo;
      RD_PGDHI:  rdata = pgdHi;
      RD_PGDSEL: rdata = faultAddr[TOP] ? pgdHi : pgdLo;
      RD_COREID: rdata = XLEN'(CORE_INDEX);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/csr_side_unit.sv
module csr_side_unit
  import csr_side_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int ASID_W     = 10,
  parameter int CORE_INDEX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrEn,
  input  logic              csrWe,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  input  logic [XLEN-1:0]   badAddr,
  input  logic [XLEN-1:0]   refillBadAddr,
  input  logic [XLEN-1:0]   refillEra,
  input  logic              timerExpire,
  output logic              timerIrq,
  output logic              flushReq
);
  strobe_t stb;

  csr_side_ctrl uCtrl (
    .csrEn     (csrEn),
    .csrWe     (csrWe),
    .csrAddr   (csrAddr),
    .wdataBit0 (csrWdata[0]),
    .stb       (stb)
  );

  csr_side_dp #(.XLEN(XLEN), .ASID_W(ASID_W), .CORE_INDEX(CORE_INDEX)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .wdata         (csrWdata),
    .badAddr       (badAddr),
    .refillBadAddr (refillBadAddr),
    .refillFlag    (refillEra[0]),
    .timerExpire   (timerExpire),
    .rdata         (csrRdata),
    .flushReq      (flushReq),
    .timerIrq      (timerIrq)
  );
endmodule

// File: rtl/csr_side_chk.sv
module csr_side_chk
  import csr_side_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int CORE_INDEX = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              csrEn,
  input logic              csrWe,
  input logic [ADDR_W-1:0] csrAddr,
  input logic [XLEN-1:0]   csrWdata,
  input logic [XLEN-1:0]   csrRdata,
  input logic              timerExpire,
  input logic              timerIrq,
  input logic              flushReq
);
  logic mapped;
  assign mapped = (csrAddr >= A_STATUS) && (csrAddr <= A_TCLR);

  p_flush_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> $past(csrEn && csrWe && csrAddr == A_ASID));

  p_expire_sets_r10: assert property (@(posedge clk) disable iff (!rstN)
    timerExpire |=> timerIrq);

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (csrEn && csrWe && csrAddr == A_TCLR && csrWdata[0] && !timerExpire) |=> !timerIrq);

  p_tclr_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (csrEn && csrAddr == A_TCLR) |-> csrRdata == '0);

  p_coreid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csrEn && csrAddr == A_COREID) |-> csrRdata == XLEN'(CORE_INDEX));

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rstN)
    (csrEn && !mapped) |-> csrRdata == '0);

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !csrEn |-> csrRdata == '0);
endmodule

bind csr_side_unit csr_side_chk #(.XLEN(XLEN), .CORE_INDEX(CORE_INDEX)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .csrEn       (csrEn),
  .csrWe       (csrWe),
  .csrAddr     (csrAddr),
  .csrWdata    (csrWdata),
  .csrRdata    (csrRdata),
  .timerExpire (timerExpire),
  .timerIrq    (timerIrq),
  .flushReq    (flushReq)
);

// File: tb/sim_csr_side_unit.sv
module sim_csr_side_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CORE_IDX   = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrEn = 1'b0, csrWe = 1'b0;
  logic [7:0]  csrAddr = '0;
  logic [63:0] csrWdata = '0, csrRdata;
  logic [63:0] badAddr = '0, refillBadAddr = '0, refillEra = '0;
  logic        timerExpire = 1'b0, timerIrq, flushReq;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference state
  logic [1:0]  mSwi = '0;
  logic [9:0]  mAsid = '0;
  logic [63:0] mLo = '0, mHi = '0;
  logic        mIrq = 1'b0, mFlush = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_side_unit #(.CORE_INDEX(CORE_IDX)) u0 (
    .clk(clk), .rstN(rstN), .csrEn(csrEn), .csrWe(csrWe), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .badAddr(badAddr),
    .refillBadAddr(refillBadAddr), .refillEra(refillEra),
    .timerExpire(timerExpire), .timerIrq(timerIrq), .flushReq(flushReq));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] modelRead(logic [7:0] a);
    logic [63:0] fa;
    fa = refillEra[0] ? refillBadAddr : badAddr;
    case (a)
      8'h01: return {52'd0, mIrq, 9'd0, mSwi};
      8'h02: return {40'd0, 8'd10, 6'd0, mAsid};
      8'h03: return mLo;
      8'h04: return mHi;
      8'h05: return fa[63] ? mHi : mLo;
      8'h06: return 64'(CORE_IDX);
      default: return '0;
    endcase
  endfunction

  // one access cycle: drive, compare, advance model
  task automatic op(string tag, bit en, bit we, logic [7:0] a, logic [63:0] wd, bit exp);
    @(negedge clk);
    csrEn = en; csrWe = we; csrAddr = a; csrWdata = wd; timerExpire = exp;
    #1;
    check({tag, " rdata"}, csrRdata, en ? modelRead(a) : 64'd0);
    check({tag, " flush"}, {63'd0, flushReq}, {63'd0, mFlush});
    check({tag, " irq"},   {63'd0, timerIrq}, {63'd0, mIrq});
    mFlush = en && we && a == 8'h02 && wd[9:0] != mAsid;
    if (en && we) begin
      case (a)
        8'h01: mSwi = wd[1:0];
        8'h02: mAsid = wd[9:0];
        8'h03: mLo = wd;
        8'h04: mHi = wd;
        default: ;
      endcase
    end
    mIrq = exp || (mIrq && !(en && we && a == 8'h07 && wd[0]));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R12 reset state
    op("R12", 0, 0, 8'h00, 0, 0);
    op("R12 status", 1, 0, 8'h01, 0, 0);
    op("R12 asid", 1, 0, 8'h02, 0, 0);
    // R2 base registers, R4 exchange
    op("R4 lo", 1, 1, 8'h03, 64'h1111_2222_3333_4444, 0);
    op("R4 hi", 1, 1, 8'h04, 64'hAAAA_BBBB_CCCC_DDDD, 0);
    op("R4 lo again", 1, 1, 8'h03, 64'h5555_0000_0000_0001, 0);
    // R1/R2 all selector combinations
    for (int k = 0; k < 4; k++) begin
      refillEra     = {63'd7, k[1]};
      badAddr       = {k[0], 63'h12};
      refillBadAddr = {~k[0], 63'h34};
      op("R1 R2 sel", 1, 0, 8'h05, 0, 0);
    end
    // R11 write to selector ignored
    op("R11 selwr", 1, 1, 8'h05, '1, 0);
    op("R11 lo kept", 1, 0, 8'h03, 0, 0);
    // R3 status mask
    op("R3 wr", 1, 1, 8'h01, '1, 0);
    op("R3 rd", 1, 0, 8'h01, 0, 0);
    op("R3 wr2", 1, 1, 8'h01, 64'h0000_0000_0000_0802, 0);
    // R5/R6 asid
    op("R5 wr", 1, 1, 8'h02, '1, 0);
    op("R6 same", 1, 1, 8'h02, 64'hFFFF_0000_0000_03FF, 0);
    op("R6 after same", 1, 0, 8'h02, 0, 0);
    op("R6 change", 1, 1, 8'h02, 64'h0000_0000_0000_0155, 0);
    op("R6 pulse", 0, 0, 8'h00, 0, 0);
    op("R6 end", 0, 0, 8'h00, 0, 0);
    // R10/R7/R8 timer
    op("R10 expire", 0, 0, 8'h00, 0, 1);
    op("R3 timer bit", 1, 0, 8'h01, 0, 0);
    op("R7 no clr", 1, 1, 8'h07, 64'hFFFF_FFFF_FFFF_FFFE, 0);
    op("R7 kept", 0, 0, 8'h00, 0, 0);
    op("R8 clr", 1, 1, 8'h07, 64'h1, 0);
    op("R7 cleared", 0, 0, 8'h00, 0, 1);
    op("R10 win", 1, 1, 8'h07, 64'h1, 1);
    op("R10 held", 1, 1, 8'h07, 64'h1, 0);
    op("R7 done", 0, 0, 8'h00, 0, 0);
    // R9 core id, write ignored
    op("R9 wr", 1, 1, 8'h06, '1, 0);
    op("R9 rd", 1, 0, 8'h06, 0, 0);
    // R11 unmapped
    op("R11 wr", 1, 1, 8'h7F, '1, 0);
    op("R11 rd", 1, 0, 8'h7F, 0, 0);
    op("R11 rd0", 1, 0, 8'h00, 0, 0);
    op("R11 hi kept", 1, 0, 8'h04, 0, 0);
    op("R11 status kept", 1, 0, 8'h01, 0, 0);
    op("R11 asid kept", 1, 0, 8'h02, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule